// File: doc/BRIEF.md
# Memory Map Access Fault Decoder

This block watches the address phase of a 32-bit processor bus and checks each access against a fixed memory map. The map contains flash, on-chip SRAM whose size is set by a static configuration input, a boot area, two reserved holes, and two peripheral spaces that are split into slots. For every valid access the block reports, one cycle later, either an abort or the peripheral slot that was selected. An abort carries a kind: instruction-fetch abort or data abort. Peripheral data accesses also return the slot index and the register offset that the slot actually decodes.

The fetch-abort kind is registered next to the access, so a pipeline can carry it with the fetched word and raise the exception only if that word is executed. Inside an assigned slot of the register peripheral space, offsets that no register uses are not faulted. Only the low offset bits that the slot needs are passed on, so an undefined offset folds onto a defined register. Which slots are assigned, and how many offset bits each register-space slot decodes, are parameters.

Top module: `mem_fault_dec`

## Requirements
- R1: Accesses to 0x0000_0000..0x3FFF_FFFF, to SRAM from 0x4000_0000 up to (not including) 0x4000_0000 + size, and to 0x7FFF_E000..0x7FFF_FFFF never abort, for fetch and data alike. Size is 2 kB for sram_cfg_i = 0, 4 kB for 1, 8 kB for 2, and 2 kB for 3.
- R2: Accesses from the end of the configured SRAM through 0x7FFF_DFFF abort.
- R3: Accesses to 0x8000_0000..0xDFFF_FFFF abort.
- R4: Any fetch (fetch_i = 1) to 0xE000_0000..0xFFFF_FFFF aborts, even when the slot is assigned.
- R5: A data access to register space (0xE000_0000..0xEFFF_FFFF) aborts when addr[27:21] is nonzero or when the bit of the APB slot mask at index addr[20:14] is clear. A data access to 0xF000_0000..0xFFFF_FFFF aborts when the bit of the AHB slot mask at index addr[27:21] is clear.
- R6: abort_kind_o is 2'b01 for an aborted fetch, 2'b10 for an aborted data access, and 2'b00 when abort_o is low.
- R7: A data access to an assigned register-space slot does not abort. It sets apb_sel_o, sets slot_o = addr[20:14], and sets off_o = addr[13:0] masked to that slot's width W, where W is taken from APB_OFF_W[5*slot +: 5] and capped at 14. With the default widths, slot 3 decodes 8 bits, so 0xE000_D000 gives slot 3 and offset 0.
- R8: A data access to an assigned AHB slot does not abort. It sets ahb_sel_o, sets slot_o = addr[27:21], and sets off_o = 0.
- R9: All outputs are registered and reflect the access presented at the previous rising edge. They are all zero during reset and after a cycle in which valid_i was low.
- R10: At most one of abort_o, apb_sel_o and ahb_sel_o is high at a time. slot_o and off_o are zero unless a select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Access present this cycle |
| fetch_i | input | 1 | 1 = instruction fetch, 0 = data access |
| addr_i | input | 32 | Access address |
| sram_cfg_i | input | 2 | Static SRAM size select |
| abort_o | output | 1 | Access faults |
| abort_kind_o | output | 2 | 01 fetch abort, 10 data abort, 00 none |
| apb_sel_o | output | 1 | Register-space slot hit |
| ahb_sel_o | output | 1 | AHB-space slot hit |
| slot_o | output | 7 | Selected slot index |
| off_o | output | 14 | Decoded byte offset within the slot |

## Verification
A wrong region comparison shows up as an abort flag that is wrong at exactly one side of a boundary, on the cycle right after the access. For this reason the bench drives both sides of every boundary, for each SRAM setting and for both access kinds. A slot mask or width that is indexed wrongly shows up as a wrong slot or offset, or as an abort where none is expected. These faults are visible on the first access to that slot, and a behavioural reference compares every output on every cycle. A register that keeps stale contents shows up when a cycle with valid_i low follows a hit or an abort.

// File: rtl/mfd_pkg.sv
package mfd_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned SLOT_IDX_W = 7;
  localparam int unsigned NUM_SLOTS  = 1 << SLOT_IDX_W;
  localparam int unsigned OFF_W      = 14;
  localparam int unsigned WFIELD_W   = 5;

  typedef enum logic [1:0] {
    ABT_NONE     = 2'b00,
    ABT_PREFETCH = 2'b01,
    ABT_DATA     = 2'b10
  } abort_kind_e;

  typedef enum logic [2:0] {
    RG_FLASH,
    RG_SRAM,
    RG_HOLE,
    RG_BOOT,
    RG_RSV,
    RG_APB,
    RG_AHB
  } region_e;

  typedef struct packed {
    logic                  abort;
    abort_kind_e           kind;
    logic                  apb_sel;
    logic                  ahb_sel;
    logic [SLOT_IDX_W-1:0] slot;
    logic [OFF_W-1:0]      off;
  } dec_out_t;
endpackage

// File: rtl/mfd_region_dec.sv
module mfd_region_dec
  import mfd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SRAM_BASE = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] SRAM_UNIT = 32'h0000_0800,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 32'h7FFF_E000,
  parameter logic [ADDR_W-1:0] RSV_BASE  = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] APB_BASE  = 32'hE000_0000,
  parameter logic [ADDR_W-1:0] AHB_BASE  = 32'hF000_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        sram_cfg_i,
  output region_e           region_o
);
  localparam int unsigned NUM_CFG = 3;

  logic [ADDR_W-1:0] sram_top [NUM_CFG];
  logic [ADDR_W-1:0] sram_end;

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_sram_top
    assign sram_top[g] = SRAM_BASE + (SRAM_UNIT << g);
  end

  always_comb begin
    unique case (sram_cfg_i)
      2'd1:    sram_end = sram_top[1];
      2'd2:    sram_end = sram_top[2];
      default: sram_end = sram_top[0];
    endcase
  end

  always_comb begin
    if (addr_i < SRAM_BASE)       region_o = RG_FLASH;
    else if (addr_i < sram_end)   region_o = RG_SRAM;
    else if (addr_i < BOOT_BASE)  region_o = RG_HOLE;
    else if (addr_i < RSV_BASE)   region_o = RG_BOOT;
    else if (addr_i < APB_BASE)   region_o = RG_RSV;
    else if (addr_i < AHB_BASE)   region_o = RG_APB;
    else                          region_o = RG_AHB;
  end
endmodule

// File: rtl/mfd_slot_dec.sv
module mfd_slot_dec
  import mfd_pkg::*;
#(
  parameter logic [NUM_SLOTS-1:0]          APB_MASK  = '1,
  parameter logic [NUM_SLOTS-1:0]          AHB_MASK  = '1,
  parameter logic [NUM_SLOTS*WFIELD_W-1:0] APB_OFF_W = {NUM_SLOTS{5'd8}}
) (
  input  logic [27:0]           addr_i,
  output logic [SLOT_IDX_W-1:0] apb_idx_o,
  output logic [SLOT_IDX_W-1:0] ahb_idx_o,
  output logic                  apb_hit_o,
  output logic                  ahb_hit_o,
  output logic [OFF_W-1:0]      apb_off_o
);
  localparam int unsigned APB_IDX_LSB = OFF_W;
  localparam int unsigned AHB_IDX_LSB = APB_IDX_LSB + SLOT_IDX_W;

  logic [OFF_W-1:0] off_mask [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_mask
    localparam int unsigned RAW_W = int'(APB_OFF_W[g*WFIELD_W +: WFIELD_W]);
    localparam int unsigned EFF_W = (RAW_W > OFF_W) ? OFF_W : RAW_W;
    assign off_mask[g] = OFF_W'((32'd1 << EFF_W) - 32'd1);
  end

  assign apb_idx_o = addr_i[APB_IDX_LSB +: SLOT_IDX_W];
  assign ahb_idx_o = addr_i[AHB_IDX_LSB +: SLOT_IDX_W];

  // Register space only indexes its low 2 MB; anything above is unassigned.
  assign apb_hit_o = (ahb_idx_o == '0) && APB_MASK[apb_idx_o];
  assign ahb_hit_o = AHB_MASK[ahb_idx_o];
  assign apb_off_o = addr_i[OFF_W-1:0] & off_mask[apb_idx_o];
endmodule

// File: rtl/mfd_fault_eval.sv
module mfd_fault_eval
  import mfd_pkg::*;
(
  input  logic                  valid_i,
  input  logic                  fetch_i,
  input  region_e               region_i,
  input  logic [SLOT_IDX_W-1:0] apb_idx_i,
  input  logic [SLOT_IDX_W-1:0] ahb_idx_i,
  input  logic                  apb_hit_i,
  input  logic                  ahb_hit_i,
  input  logic [OFF_W-1:0]      apb_off_i,
  output dec_out_t              dec_o
);
  logic periph;
  logic fault;

  assign periph = (region_i == RG_APB) || (region_i == RG_AHB);

  always_comb begin
    unique case (region_i)
      RG_HOLE, RG_RSV: fault = 1'b1;
      RG_APB:          fault = fetch_i || !apb_hit_i;
      RG_AHB:          fault = fetch_i || !ahb_hit_i;
      default:         fault = 1'b0;
    endcase
  end

  always_comb begin
    dec_o = '0;
    if (valid_i) begin
      if (fault) begin
        dec_o.abort = 1'b1;
        dec_o.kind  = fetch_i ? ABT_PREFETCH : ABT_DATA;
      end else if (periph) begin
        if (region_i == RG_APB) begin
          dec_o.apb_sel = 1'b1;
          dec_o.slot    = apb_idx_i;
          dec_o.off     = apb_off_i;
        end else begin
          dec_o.ahb_sel = 1'b1;
          dec_o.slot    = ahb_idx_i;
        end
      end
    end
  end
endmodule

// File: rtl/mem_fault_dec.sv
module mem_fault_dec
  import mfd_pkg::*;
#(
  parameter logic [NUM_SLOTS-1:0]          APB_MASK  = 128'h8000_0000_0000_0000_0000_0000_0000_0FFF,
  parameter logic [NUM_SLOTS-1:0]          AHB_MASK  = 128'h8000_0000_0000_0000_0000_0000_0000_0001,
  parameter logic [NUM_SLOTS*WFIELD_W-1:0] APB_OFF_W = {{(NUM_SLOTS-4){5'd8}}, 5'd8, 5'd4, 5'd14, 5'd2}
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic                  fetch_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [1:0]            sram_cfg_i,
  output logic                  abort_o,
  output logic [1:0]            abort_kind_o,
  output logic                  apb_sel_o,
  output logic                  ahb_sel_o,
  output logic [SLOT_IDX_W-1:0] slot_o,
  output logic [OFF_W-1:0]      off_o
);
  region_e               region;
  logic [SLOT_IDX_W-1:0] apb_idx, ahb_idx;
  logic                  apb_hit, ahb_hit;
  logic [OFF_W-1:0]      apb_off;
  dec_out_t              dec_d, dec_q;

  mfd_region_dec u_region (
    .addr_i     (addr_i),
    .sram_cfg_i (sram_cfg_i),
    .region_o   (region)
  );

  mfd_slot_dec #(
    .APB_MASK  (APB_MASK),
    .AHB_MASK  (AHB_MASK),
    .APB_OFF_W (APB_OFF_W)
  ) u_slot (
    .addr_i    (addr_i[27:0]),
    .apb_idx_o (apb_idx),
    .ahb_idx_o (ahb_idx),
    .apb_hit_o (apb_hit),
    .ahb_hit_o (ahb_hit),
    .apb_off_o (apb_off)
  );

  mfd_fault_eval u_eval (
    .valid_i   (valid_i),
    .fetch_i   (fetch_i),
    .region_i  (region),
    .apb_idx_i (apb_idx),
    .ahb_idx_i (ahb_idx),
    .apb_hit_i (apb_hit),
    .ahb_hit_i (ahb_hit),
    .apb_off_i (apb_off),
    .dec_o     (dec_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dec_q <= '0;
    else         dec_q <= dec_d;
  end

  assign abort_o      = dec_q.abort;
  assign abort_kind_o = dec_q.kind;
  assign apb_sel_o    = dec_q.apb_sel;
  assign ahb_sel_o    = dec_q.ahb_sel;
  assign slot_o       = dec_q.slot;
  assign off_o        = dec_q.off;
endmodule

// File: rtl/mfd_checker.sv
module mfd_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic        fetch_i,
  input logic [31:0] addr_i,
  input logic [1:0]  sram_cfg_i,
  input logic        abort_o,
  input logic [1:0]  abort_kind_o,
  input logic        apb_sel_o,
  input logic        ahb_sel_o,
  input logic [6:0]  slot_o,
  input logic [13:0] off_o
);
  assert_idle_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> !abort_o && !apb_sel_o && !ahb_sel_o);

  assert_kind_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (abort_kind_o == ($past(fetch_i) ? 2'b01 : 2'b10)));

  assert_kind_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !abort_o |-> abort_kind_o == 2'b00);

  assert_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({abort_o, apb_sel_o, ahb_sel_o}));

  assert_idle_fields_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(apb_sel_o || ahb_sel_o) |-> slot_o == '0 && off_o == '0);

  assert_periph_fetch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && fetch_i && addr_i[31:29] == 3'b111) |-> abort_o && abort_kind_o == 2'b01);

  assert_rsv_hi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && addr_i >= 32'h8000_0000 && addr_i <= 32'hDFFF_FFFF) |-> abort_o);

  assert_hole_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && addr_i >= 32'h4000_2000 && addr_i <= 32'h7FFF_DFFF) |-> abort_o);

  assert_sram8k_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && sram_cfg_i == 2'd2 && addr_i[31:13] == 19'h2_0000) |-> !abort_o);

  assert_ahb_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ahb_sel_o |-> off_o == '0);
endmodule

bind mem_fault_dec mfd_checker u_chk (.*);

// File: tb/mem_fault_dec_tb.sv
module mem_fault_dec_tb;
  localparam logic [127:0] T_APB_MASK = 128'h8000_0000_0000_0000_0000_0000_0000_0FFF;
  localparam logic [127:0] T_AHB_MASK = 128'h8000_0000_0000_0000_0000_0000_0000_0001;
  localparam logic [639:0] T_OFF_W    = {{124{5'd8}}, 5'd8, 5'd4, 5'd14, 5'd2};

  typedef struct {
    bit        abort;
    bit [1:0]  kind;
    bit        apb;
    bit        ahb;
    bit [6:0]  slot;
    bit [13:0] off;
    string     tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        fetch = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  cfg = 2'd0;
  logic        abort;
  logic [1:0]  kind;
  logic        apb_sel, ahb_sel;
  logic [6:0]  slot;
  logic [13:0] off;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;
  exp_t exp_q;

  always #5 clk = ~clk;

  mem_fault_dec #(
    .APB_MASK  (T_APB_MASK),
    .AHB_MASK  (T_AHB_MASK),
    .APB_OFF_W (T_OFF_W)
  ) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .valid_i      (valid),
    .fetch_i      (fetch),
    .addr_i       (addr),
    .sram_cfg_i   (cfg),
    .abort_o      (abort),
    .abort_kind_o (kind),
    .apb_sel_o    (apb_sel),
    .ahb_sel_o    (ahb_sel),
    .slot_o       (slot),
    .off_o        (off)
  );

  function automatic exp_t ref_model(bit v, bit f, bit [31:0] a, bit [1:0] c);
    exp_t e;
    longint ua, sram_end;
    int w;
    bit flt;
    e = '{abort: 0, kind: 0, apb: 0, ahb: 0, slot: 0, off: 0, tag: "R9"};
    if (!v) return e;
    ua = longint'(a);
    sram_end = 64'h4000_0000 + (64'd2048 << ((c == 2'd1) ? 1 : (c == 2'd2) ? 2 : 0));
    flt = 0;
    if (ua < 64'h4000_0000 || ua < sram_end) e.tag = "R1";
    else if (ua <= 64'h7FFF_DFFF) begin flt = 1; e.tag = "R2"; end
    else if (ua <= 64'h7FFF_FFFF) e.tag = "R1";
    else if (ua <= 64'hDFFF_FFFF) begin flt = 1; e.tag = "R3"; end
    else if (f) begin flt = 1; e.tag = "R4"; end
    else if (ua < 64'hF000_0000) begin
      if (a[27:21] == 0 && T_APB_MASK[a[20:14]]) begin
        w = int'(T_OFF_W[a[20:14]*5 +: 5]);
        if (w > 14) w = 14;
        e.apb = 1; e.slot = a[20:14];
        e.off = a[13:0] & 14'((1 << w) - 1);
        e.tag = "R7";
      end else begin flt = 1; e.tag = "R5"; end
    end else begin
      if (T_AHB_MASK[a[27:21]]) begin
        e.ahb = 1; e.slot = a[27:21]; e.tag = "R8";
      end else begin flt = 1; e.tag = "R5"; end
    end
    if (flt) begin e.abort = 1; e.kind = f ? 2'b01 : 2'b10; end
    return e;
  endfunction

  task automatic compare(exp_t e);
    n_chk++;
    if (abort !== e.abort || kind !== e.kind || apb_sel !== e.apb ||
        ahb_sel !== e.ahb || slot !== e.slot || off !== e.off) begin
      n_fail++;
      $display("FAIL %s: got abort=%0b kind=%0d apb=%0b ahb=%0b slot=%0d off=%h exp abort=%0b kind=%0d apb=%0b ahb=%0b slot=%0d off=%h",
               e.tag, abort, kind, apb_sel, ahb_sel, slot, off,
               e.abort, e.kind, e.apb, e.ahb, e.slot, e.off);
    end
  endtask

  // Check the previous access, then present the next one.
  task automatic step(bit v, bit f, bit [31:0] a, bit [1:0] c);
    @(negedge clk);
    compare(exp_q);
    valid = v; fetch = f; addr = a; cfg = c;
    exp_q = ref_model(v, f, a, c);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got hung run exp completion");
    finish_run();
  end

  initial begin
    bit [31:0] pts [22];
    exp_t e;
    exp_q = ref_model(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R9: reset state
    compare(ref_model(0, 0, 0, 0));
    rst_n = 1'b1;

    // R7: worked aliasing case at slot 3
    step(1, 0, 32'hE000_D000, 2'd0);
    e = exp_q;
    step(0, 0, 32'h0, 2'd0);
    n_chk++;
    if (!(e.apb && e.slot == 7'd3 && e.off == 14'd0)) begin
      n_fail++;
      $display("FAIL R7: got ref slot=%0d off=%h exp slot=3 off=0", e.slot, e.off);
    end

    // R1 R2 R3 R4 R5 R8: boundary sweep for every SRAM size and access kind
    for (int c = 0; c < 4; c++) begin
      for (int f = 0; f < 2; f++) begin
        bit [31:0] se;
        se = 32'h4000_0000 + (32'd2048 << ((c == 1) ? 1 : (c == 2) ? 2 : 0));
        pts = '{32'h0, 32'h3FFF_FFFF, 32'h4000_0000, se - 1, se, 32'h7FFF_DFFF,
                32'h7FFF_E000, 32'h7FFF_FFFF, 32'h8000_0000, 32'hDFFF_FFFF,
                32'hE000_0000, 32'hE000_D000, 32'hE002_FFFC, 32'hE003_0000,
                32'hE01F_C004, 32'hE020_0000, 32'hEFFF_FFFF, 32'hF000_0000,
                32'hF020_0000, 32'hFFE0_0010, 32'hFFFF_FFFF, 32'hE000_7FFF};
        for (int i = 0; i < 22; i++) begin
          step(1, f[0], pts[i], c[1:0]);
        end
        step(0, 0, 32'hE000_0000, c[1:0]);
      end
    end

    // R9 R10: random mix with idle cycles
    for (int i = 0; i < 4000; i++) begin
      bit [31:0] a;
      int sel;
      sel = int'($urandom % 6);
      case (sel)
        0: a = $urandom;
        1: a = 32'h4000_0000 | ($urandom & 32'h3FFF);
        2: a = 32'hE000_0000 | ($urandom & 32'h003F_FFFF);
        3: a = 32'hF000_0000 | ($urandom & 32'h0FFF_FFFF);
        4: a = 32'h7FFF_C000 | ($urandom & 32'h3FFF);
        default: a = 32'hFFE0_0000 | ($urandom & 32'h001F_FFFF);
      endcase
      step(($urandom % 5) != 0, $urandom % 2 == 1, a, 2'($urandom % 4));
    end
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    finish_run();
  end
endmodule